// File: doc/BRIEF.md
# Typed Breakpoint Match Table

This block keeps a small ordered list of breakpoints. Each entry holds an address and a type code. Control logic uses it in two ways. Through the operation port it adds an entry at the end of the list, or removes an entry named by both its address and its type. Through the lookup port it presents the current program counter and learns at once whether a breakpoint sits there and, if so, the type of that breakpoint.

The list is always dense and keeps insertion order. When an entry is removed, every later entry moves down one slot, one slot per clock cycle, so the relative order of the survivors never changes. Lookup is purely combinational and stays usable while a removal is still moving entries. While that move is in progress the operation port refuses new requests. Each accepted add or remove ends with a one-cycle completion pulse that carries a success flag and an overflow flag.

Top module: `bkpt_table`

## Requirements
- R1: After reset the entry count is 0, `busy`, `op_done` and `look_hit` are low, and `look_type` is 0.
- R2: An accepted add (`op_code` 2'b01) with fewer than DEPTH entries stores the address and type in the slot whose index equals the current count. The count rises by one and, in the next cycle, `op_done` pulses with `op_ok` high.
- R3: An add while the table holds DEPTH entries leaves the table unchanged. In the next cycle, `op_done` pulses with `op_overflow` high and `op_ok` low.
- R4: An accepted clear (`op_code` 2'b10) removes only the lowest-index entry whose address and type both equal the request. The count drops by one and completion reports `op_ok` high.
- R5: A clear with no entry matching both fields leaves the table and the count unchanged. In the next cycle, `op_done` pulses with `op_ok` low.
- R6: After a removal the remaining entries keep their original relative order, so lookup priority among them is unchanged.
- R7: Lookup compares the address only. It raises `look_hit` and returns the type of the lowest-index entry whose address equals `look_pc`, in the same cycle.
- R8: When no entry has the address `look_pc`, `look_hit` is 0 and `look_type` is 0.
- R9: A clear that removes slot i of a table holding n entries moves n-1-i entries, one per cycle. `busy` is high during those cycles, and `op_done` is seen n-i cycles after the accepting edge.
- R10: An operation presented while `busy` is high is ignored. It produces no completion pulse and does not change the table.
- R11: While a clear is moving entries, lookup never reports the removed entry and still reports every remaining entry with its type.
- R12: The op codes 2'b00 and 2'b11 are ignored even when `op_valid` is high. They give no completion pulse and leave the table unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation request strobe |
| op_code | input | 2 | 01 add, 10 clear, others ignored |
| op_addr | input | AW (32) | Address of the operation |
| op_type | input | TW (4) | Type code of the operation |
| look_pc | input | AW (32) | Address presented for lookup |
| look_hit | output | 1 | An entry at `look_pc` exists |
| look_type | output | TW (4) | Type of the first matching entry, 0 on a miss |
| op_done | output | 1 | One-cycle completion pulse |
| op_ok | output | 1 | Operation succeeded, valid with `op_done` |
| op_overflow | output | 1 | Add rejected because the table is full, valid with `op_done` |
| busy | output | 1 | A clear is still moving entries |
| entry_count | output | $clog2(DEPTH+1) (4) | Number of stored entries |

## Verification
Lookup and the entry moves of a clear can fall in the same cycle. A lookup during a move reads slots that are half moved. The bench keeps `look_pc` on a removed or surviving address through every cycle of a long clear, and compares the hit and type in each of those cycles against a model that drops the entry at the moment the clear is accepted. In the middle of the same move it also presents an add. It judges that add refused when no extra completion reaches the scoreboard and the count and lookups stay equal to the model.

// File: rtl/bkpt_pkg.sv
package bkpt_pkg;

   typedef enum logic [1:0] {
      BK_NOP = 2'b00,
      BK_ADD = 2'b01,
      BK_CLR = 2'b10,
      BK_RSV = 2'b11
   } bk_op_e;

   typedef enum logic {
      ST_IDLE  = 1'b0,
      ST_SHIFT = 1'b1
   } bk_state_e;

   function automatic int unsigned idx_bits(input int unsigned depth);
      return (depth <= 2) ? 1 : $clog2(depth);
   endfunction

endpackage

// File: rtl/bkpt_match.sv
// First-match search over the slots; USE_TYPE selects whether the type field takes part.
module bkpt_match #(
   parameter int unsigned DEPTH    = 8,
   parameter int unsigned AW       = 32,
   parameter int unsigned TW       = 4,
   parameter bit          USE_TYPE = 1'b0,
   localparam int unsigned IW      = bkpt_pkg::idx_bits(DEPTH)
) (
   input  logic [DEPTH-1:0] slot_vld,
   input  logic [AW-1:0]    slot_addr [DEPTH],
   input  logic [TW-1:0]    slot_type [DEPTH],
   input  logic [AW-1:0]    key_addr,
   input  logic [TW-1:0]    key_type,
   output logic             hit,
   output logic [IW-1:0]    idx
);

   logic [DEPTH-1:0] eq;

   for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
      if (USE_TYPE) begin : g_full
         assign eq[g] = slot_vld[g] && (slot_addr[g] == key_addr) && (slot_type[g] == key_type);
      end else begin : g_addr
         assign eq[g] = slot_vld[g] && (slot_addr[g] == key_addr);
      end
   end

   assign hit = |eq;

   // Lowest index wins: scan downward so the last assignment is the lowest hit.
   always_comb begin
      idx = '0;
      for (int i = DEPTH - 1; i >= 0; i--) begin
         if (eq[i]) idx = IW'(i);
      end
   end

endmodule

// File: rtl/bkpt_store.sv
// Slot registers with load, invalidate and move-down-by-one.
module bkpt_store #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned TW    = 4,
   localparam int unsigned IW   = bkpt_pkg::idx_bits(DEPTH)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [IW-1:0]    wr_idx,
   input  logic [AW-1:0]    wr_addr,
   input  logic [TW-1:0]    wr_type,
   input  logic             kill_en,
   input  logic [IW-1:0]    kill_idx,
   input  logic             shift_en,
   input  logic [IW-1:0]    shift_idx,
   output logic [DEPTH-1:0] slot_vld,
   output logic [AW-1:0]    slot_addr [DEPTH],
   output logic [TW-1:0]    slot_type [DEPTH]
);

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      logic          nb_vld;
      logic [AW-1:0] nb_addr;
      logic [TW-1:0] nb_type;
      logic          take_nb;
      logic          drop_me;

      if (g < DEPTH - 1) begin : g_has_nb
         assign nb_vld  = slot_vld[g+1];
         assign nb_addr = slot_addr[g+1];
         assign nb_type = slot_type[g+1];
         assign take_nb = shift_en && (shift_idx == IW'(g));
      end else begin : g_top
         assign nb_vld  = 1'b0;
         assign nb_addr = '0;
         assign nb_type = '0;
         assign take_nb = 1'b0;
      end

      // The slot just vacated by a move becomes the new hole.
      if (g > 0) begin : g_can_drop
         assign drop_me = shift_en && (shift_idx == IW'(g - 1));
      end else begin : g_bottom
         assign drop_me = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            slot_vld[g]  <= 1'b0;
            slot_addr[g] <= '0;
            slot_type[g] <= '0;
         end else if (wr_en && (wr_idx == IW'(g))) begin
            slot_vld[g]  <= 1'b1;
            slot_addr[g] <= wr_addr;
            slot_type[g] <= wr_type;
         end else if (kill_en && (kill_idx == IW'(g))) begin
            slot_vld[g]  <= 1'b0;
         end else if (take_nb) begin
            slot_vld[g]  <= nb_vld;
            slot_addr[g] <= nb_addr;
            slot_type[g] <= nb_type;
         end else if (drop_me) begin
            slot_vld[g]  <= 1'b0;
         end
      end
   end

endmodule

// File: rtl/bkpt_ctrl.sv
// Operation sequencer: accepts add/clear, runs the move-down sequence, reports completion.
module bkpt_ctrl #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned IW   = bkpt_pkg::idx_bits(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [1:0]    op_code,
   input  logic          clr_hit,
   input  logic [IW-1:0] clr_idx,
   output logic          wr_en,
   output logic [IW-1:0] wr_idx,
   output logic          kill_en,
   output logic [IW-1:0] kill_idx,
   output logic          shift_en,
   output logic [IW-1:0] shift_idx,
   output logic [CW-1:0] count,
   output logic          busy,
   output logic          done,
   output logic          ok,
   output logic          ovf
);
   import bkpt_pkg::*;

   bk_state_e     state;
   logic [IW-1:0] ptr;
   logic [IW-1:0] last;
   logic          accept, is_add, is_clr, room, clr_at_end;

   assign accept     = op_valid && (state == ST_IDLE);
   assign is_add     = accept && (bk_op_e'(op_code) == BK_ADD);
   assign is_clr     = accept && (bk_op_e'(op_code) == BK_CLR);
   assign room       = count < CW'(DEPTH);
   assign clr_at_end = (CW'(clr_idx) + CW'(1)) == count;

   assign wr_en     = is_add && room;
   assign wr_idx    = IW'(count);
   assign kill_en   = is_clr && clr_hit;
   assign kill_idx  = clr_idx;
   assign shift_en  = (state == ST_SHIFT);
   assign shift_idx = ptr;
   assign busy      = (state == ST_SHIFT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         ptr   <= '0;
         last  <= '0;
         count <= '0;
         done  <= 1'b0;
         ok    <= 1'b0;
         ovf   <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (is_add) begin
                  done <= 1'b1;
                  ok   <= room;
                  ovf  <= !room;
                  if (room) count <= count + CW'(1);
               end else if (is_clr) begin
                  ovf <= 1'b0;
                  if (!clr_hit) begin
                     done <= 1'b1;
                     ok   <= 1'b0;
                  end else begin
                     count <= count - CW'(1);
                     if (clr_at_end) begin
                        done <= 1'b1;
                        ok   <= 1'b1;
                     end else begin
                        state <= ST_SHIFT;
                        ptr   <= clr_idx;
                        last  <= IW'(count - CW'(1));
                     end
                  end
               end
            end
            ST_SHIFT: begin
               ptr <= ptr + IW'(1);
               if ((ptr + IW'(1)) == last) begin
                  state <= ST_IDLE;
                  done  <= 1'b1;
                  ok    <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/bkpt_table.sv
module bkpt_table #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned AW    = 32,
   parameter int unsigned TW    = 4,
   localparam int unsigned IW   = bkpt_pkg::idx_bits(DEPTH),
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          op_valid,
   input  logic [1:0]    op_code,
   input  logic [AW-1:0] op_addr,
   input  logic [TW-1:0] op_type,
   input  logic [AW-1:0] look_pc,
   output logic          look_hit,
   output logic [TW-1:0] look_type,
   output logic          op_done,
   output logic          op_ok,
   output logic          op_overflow,
   output logic          busy,
   output logic [CW-1:0] entry_count
);

   if (DEPTH < 2) begin : g_bad_depth
      $error("bkpt_table: DEPTH must be at least 2");
   end
   if (AW < 1 || TW < 1) begin : g_bad_width
      $error("bkpt_table: AW and TW must be non-zero");
   end

   logic [DEPTH-1:0] slot_vld;
   logic [AW-1:0]    slot_addr [DEPTH];
   logic [TW-1:0]    slot_type [DEPTH];

   logic          lk_hit, clr_hit;
   logic [IW-1:0] lk_idx, clr_idx;
   logic          wr_en, kill_en, shift_en;
   logic [IW-1:0] wr_idx, kill_idx, shift_idx;

   bkpt_store #(.DEPTH(DEPTH), .AW(AW), .TW(TW)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .wr_addr   (op_addr),
      .wr_type   (op_type),
      .kill_en   (kill_en),
      .kill_idx  (kill_idx),
      .shift_en  (shift_en),
      .shift_idx (shift_idx),
      .slot_vld  (slot_vld),
      .slot_addr (slot_addr),
      .slot_type (slot_type)
   );

   bkpt_match #(.DEPTH(DEPTH), .AW(AW), .TW(TW), .USE_TYPE(1'b0)) u_look (
      .slot_vld  (slot_vld),
      .slot_addr (slot_addr),
      .slot_type (slot_type),
      .key_addr  (look_pc),
      .key_type  ('0),
      .hit       (lk_hit),
      .idx       (lk_idx)
   );

   bkpt_match #(.DEPTH(DEPTH), .AW(AW), .TW(TW), .USE_TYPE(1'b1)) u_find (
      .slot_vld  (slot_vld),
      .slot_addr (slot_addr),
      .slot_type (slot_type),
      .key_addr  (op_addr),
      .key_type  (op_type),
      .hit       (clr_hit),
      .idx       (clr_idx)
   );

   bkpt_ctrl #(.DEPTH(DEPTH)) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .op_valid  (op_valid),
      .op_code   (op_code),
      .clr_hit   (clr_hit),
      .clr_idx   (clr_idx),
      .wr_en     (wr_en),
      .wr_idx    (wr_idx),
      .kill_en   (kill_en),
      .kill_idx  (kill_idx),
      .shift_en  (shift_en),
      .shift_idx (shift_idx),
      .count     (entry_count),
      .busy      (busy),
      .done      (op_done),
      .ok        (op_ok),
      .ovf       (op_overflow)
   );

   assign look_hit  = lk_hit;
   assign look_type = lk_hit ? slot_type[lk_idx] : '0;

endmodule

// File: rtl/bkpt_table_chk.sv
module bkpt_table_chk #(
   parameter int unsigned DEPTH = 8,
   parameter int unsigned TW    = 4,
   localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          op_valid,
   input logic [1:0]    op_code,
   input logic          look_hit,
   input logic [TW-1:0] look_type,
   input logic          op_done,
   input logic          op_ok,
   input logic          op_overflow,
   input logic          busy,
   input logic [CW-1:0] entry_count
);

   logic take_add, take_clr, take_bad;
   assign take_add = op_valid && !busy && (op_code == 2'b01);
   assign take_clr = op_valid && !busy && (op_code == 2'b10);
   assign take_bad = op_valid && !busy && (op_code == 2'b00 || op_code == 2'b11);

   p_count_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      entry_count <= CW'(DEPTH));

   p_add_grow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (take_add && entry_count < CW'(DEPTH)) |=>
         (entry_count == $past(entry_count) + CW'(1)) && op_done && op_ok && !op_overflow);

   p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (take_add && entry_count == CW'(DEPTH)) |=>
         op_done && op_overflow && !op_ok && $stable(entry_count));

   p_clear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      take_clr |=> (entry_count == $past(entry_count)) ||
                   (entry_count == $past(entry_count) - CW'(1)));

   p_miss_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !look_hit |-> look_type == '0);

   p_empty_miss_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (entry_count == '0 && !busy) |-> !look_hit);

   p_done_vs_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !(op_done && busy));

   p_refuse_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> entry_count == $past(entry_count));

   p_ignore_code_r12: assert property (@(posedge clk) disable iff (!rst_n)
      take_bad |=> !op_done && $stable(entry_count));

endmodule

bind bkpt_table bkpt_table_chk #(.DEPTH(DEPTH), .TW(TW)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .op_valid    (op_valid),
   .op_code     (op_code),
   .look_hit    (look_hit),
   .look_type   (look_type),
   .op_done     (op_done),
   .op_ok       (op_ok),
   .op_overflow (op_overflow),
   .busy        (busy),
   .entry_count (entry_count)
);

// File: tb/bkpt_table_bench.sv
module bkpt_table_bench;
   localparam int CLK_P = 10;
   localparam int DEPTH = 8;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        op_valid = 1'b0;
   logic [1:0]  op_code = 2'b00;
   logic [31:0] op_addr = '0;
   logic [3:0]  op_type = '0;
   logic [31:0] look_pc = '0;
   logic        look_hit, op_done, op_ok, op_overflow, busy;
   logic [3:0]  look_type, entry_count;

   bkpt_table u_bkpt_table (
      .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
      .op_addr(op_addr), .op_type(op_type), .look_pc(look_pc),
      .look_hit(look_hit), .look_type(look_type), .op_done(op_done),
      .op_ok(op_ok), .op_overflow(op_overflow), .busy(busy),
      .entry_count(entry_count)
   );

   always #(CLK_P / 2) clk = ~clk;

   int n_chk = 0;
   int n_bad = 0;

   typedef struct { bit ok; bit ovf; string tag; } exp_t;
   exp_t exp_q[$];

   bit [31:0] m_addr[$];
   bit [3:0]  m_type[$];

   task automatic check(input bit cond, input string tag, input string what,
                        input longint act, input longint expv);
      n_chk++;
      if (!cond) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   // Monitor: every completion pulse is popped against the scoreboard.
   always @(negedge clk) begin
      if (rst_n && op_done) begin
         if (exp_q.size() == 0) begin
            check(1'b0, "R10/R12", "unexpected completion", 1, 0);
         end else begin
            exp_t e;
            e = exp_q.pop_front();
            check(op_ok == e.ok, e.tag, "op_ok", op_ok, e.ok);
            check(op_overflow == e.ovf, e.tag, "op_overflow", op_overflow, e.ovf);
         end
      end
   end

   function automatic int model_find(input bit [31:0] a, input bit [3:0] t, input bit use_t);
      for (int i = 0; i < m_addr.size(); i++)
         if (m_addr[i] == a && (!use_t || m_type[i] == t)) return i;
      return -1;
   endfunction

   task automatic cmp_lookup(input string tag);
      int i;
      i = model_find(look_pc, 4'h0, 1'b0);
      check(look_hit == (i >= 0), tag, "look_hit", look_hit, i >= 0);
      check(look_type == ((i >= 0) ? m_type[i] : 4'h0), tag, "look_type",
            look_type, (i >= 0) ? m_type[i] : 4'h0);
   endtask

   task automatic look(input bit [31:0] pc, input string tag);
      look_pc = pc;
      #1;
      cmp_lookup(tag);
   endtask

   task automatic drive(input bit [1:0] c, input bit [31:0] a, input bit [3:0] t);
      op_valid = 1'b1; op_code = c; op_addr = a; op_type = t;
   endtask

   task automatic do_add(input bit [31:0] a, input bit [3:0] t, input string tag);
      exp_t e;
      e.ok = m_addr.size() < DEPTH; e.ovf = !e.ok; e.tag = tag;
      exp_q.push_back(e);
      if (e.ok) begin m_addr.push_back(a); m_type.push_back(t); end
      @(negedge clk); drive(2'b01, a, t);
      @(negedge clk); op_valid = 1'b0;
      check(op_done == 1'b1, tag, "add done latency", op_done, 1);
      check(entry_count == 4'(m_addr.size()), tag, "entry_count", entry_count, m_addr.size());
   endtask

   task automatic do_clr(input bit [31:0] a, input bit [3:0] t, input bit poke, input string tag);
      exp_t e;
      int idx, k, n;
      idx = model_find(a, t, 1'b1);
      k = (idx >= 0) ? m_addr.size() - 1 - idx : 0;
      e.ok = idx >= 0; e.ovf = 1'b0; e.tag = tag;
      exp_q.push_back(e);
      if (idx >= 0) begin m_addr.delete(idx); m_type.delete(idx); end
      @(negedge clk); drive(2'b10, a, t);
      n = 0;
      do begin
         @(negedge clk);
         n++;
         if (n == 1) begin
            op_valid = 1'b0;
            if (poke && k >= 2) drive(2'b01, 32'hDEAD_0000, 4'hF); // R10: refused
         end else begin
            op_valid = 1'b0;
         end
         #1;
         cmp_lookup("R11");
         if (n <= k) check(busy == 1'b1, "R9", "busy during move", busy, 1);
      end while (!op_done && n < 40);
      check(n == k + 1, "R9", "clear latency", n, k + 1);
      check(entry_count == 4'(m_addr.size()), tag, "entry_count", entry_count, m_addr.size());
   endtask

   initial begin
      repeat (5000) @(posedge clk);
      check(1'b0, "WDOG", "watchdog expired", 0, 1);
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      check(entry_count == 0, "R1", "reset count", entry_count, 0);
      check(busy == 0 && op_done == 0, "R1", "reset busy/done", {busy, op_done}, 0);
      look(32'h100, "R1");
      rst_n = 1'b1;
      @(negedge clk);
      look(32'h999, "R8");

      do_add(32'h100, 4'h1, "R2");
      do_add(32'h200, 4'h2, "R2");
      do_add(32'h100, 4'h3, "R2");
      do_add(32'h300, 4'h4, "R2");
      do_add(32'h200, 4'h5, "R2");
      do_add(32'h400, 4'h6, "R2");
      do_add(32'h500, 4'h7, "R2");
      do_add(32'h100, 4'h8, "R2");
      look(32'h100, "R7"); look(32'h200, "R7"); look(32'h300, "R7");
      look(32'h500, "R7"); look(32'h999, "R8");

      do_add(32'h600, 4'h9, "R3");
      look(32'h600, "R3");

      // Address 100 sits at slot 0 with another type; the type-3 entry at slot 2 goes.
      look_pc = 32'h100;
      do_clr(32'h100, 4'h3, 1'b1, "R4");
      check(exp_q.size() == 0, "R10", "refused add produced no completion", exp_q.size(), 0);
      look(32'hDEAD_0000, "R10");

      do_clr(32'h777, 4'h1, 1'b0, "R5");
      do_clr(32'h200, 4'h9, 1'b0, "R5");
      look(32'h200, "R5");

      look_pc = 32'h100;
      do_clr(32'h100, 4'h1, 1'b0, "R4");
      look(32'h100, "R6");
      do_clr(32'h100, 4'h8, 1'b0, "R9");
      look(32'h100, "R8");

      @(negedge clk); drive(2'b00, 32'h700, 4'h2);
      @(negedge clk); drive(2'b11, 32'h700, 4'h2);
      @(negedge clk); op_valid = 1'b0;
      @(negedge clk);
      check(entry_count == 4'(m_addr.size()), "R12", "count after ignored codes",
            entry_count, m_addr.size());
      look(32'h700, "R12");

      do_add(32'h200, 4'hA, "R2");
      look(32'h200, "R7");
      look_pc = 32'h200;
      do_clr(32'h200, 4'h2, 1'b0, "R6");
      look(32'h200, "R6");
      foreach (m_addr[i]) look(m_addr[i], "R6");

      repeat (3) @(negedge clk);
      check(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 0);
      summary();
   end
endmodule